// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the data side of a small processor. A single internal bus of `WIDTH` bits connects three possible sources: the external data input, a general register X and a result register Z. Any register load strobe captures the bus value at the clock edge of the same cycle in which the value is driven. The bus itself holds nothing between cycles.

An accumulator A is wired straight into the first operand of a two-bit-opcode ALU. The second operand is whatever the bus carries in that cycle. The ALU result, together with its zero and carry flags, is stored in Z when Z's strobe is raised. Z is always visible at the data output, and Z can also be put back onto the bus so that X or A can reuse it.

The block has no sequencer. A separate controller or a testbench applies one control word per cycle. Each control word holds the bus source enables, the load strobes and the opcode.

Top module: `acc_bus_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears X, A, Z, the zero flag and the carry flag. After the reset edge, `data_out` is 0 and both flags are 0.
- R2: While `drv_in` is the only enable, the bus equals `data_in`. A register whose strobe (`ld_x` or `ld_a`) is high captures that value at the same edge. With no enable active, the bus reads 0.
- R3: The ALU's first operand is A and its second operand is the bus in the same cycle. `alu_op` encodes 2'b00 add, 2'b01 subtract (A minus bus), 2'b10 bitwise AND and 2'b11 bitwise OR. `ld_z` stores the low `WIDTH` bits of the result into Z.
- R4: `data_out` always shows Z. While `drv_z` is the only enable, the bus carries Z, and X or A can load it.
- R5: When Z is loaded, the zero flag is set exactly when the stored result is all zeros.
- R6: When Z is loaded, the carry flag is updated as follows:
  - For add, it is the carry out of the top bit.
  - For subtract with the default `SUB_BORROW=1`, it is set when the bus value is larger than A as unsigned numbers.
  - For AND and OR, it is 0.
- R7: When more than one of `drv_in`, `drv_x` and `drv_z` is high, `bus_conflict` is high in that same cycle and the bus reads 0. Otherwise `bus_conflict` is low.
- R8: A register whose strobe is low keeps its value. Z and both flags keep their values whenever `ld_z` is low.
- R9: Strobes raised together all act on the same edge. With `ld_a` and `ld_z` both high, Z receives the result formed from the old A, while A takes the bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | WIDTH | External data that can be driven onto the bus |
| drv_in | input | 1 | Put `data_in` on the bus |
| drv_x | input | 1 | Put register X on the bus |
| drv_z | input | 1 | Put register Z on the bus |
| ld_x | input | 1 | Load X from the bus |
| ld_a | input | 1 | Load accumulator A from the bus |
| ld_z | input | 1 | Load Z and the flags from the ALU |
| alu_op | input | 2 | ALU operation: 00 add, 01 sub, 10 AND, 11 OR |
| data_out | output | WIDTH | Current content of Z |
| zero_flag | output | 1 | Registered zero flag |
| carry_flag | output | 1 | Registered carry/borrow flag |
| bus_conflict | output | 1 | More than one bus source enabled this cycle |

## Verification
The embedded properties assume the following about the block's inputs:
- Control inputs change only between rising edges.
- `rst` is high at the first edge, so the reset check has a defined past.

The load-capture property applies only when `drv_in` is the sole enable, because it relates the captured value to `data_in`. The directed stimulus drives every control word on the falling edge and keeps a single enable in all scenarios except the conflict scenarios. Those scenarios raise two or three enables on purpose and then read the affected register back through Z using a single clean enable.

// File: rtl/acc_bus_pkg.sv
package acc_bus_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_AND = 2'b10,
      OP_OR  = 2'b11
   } alu_op_e;

   // bus source slots (index into the source vector)
   localparam int SRC_IN    = 0;
   localparam int SRC_X     = 1;
   localparam int SRC_Z     = 2;
   localparam int SRC_COUNT = 3;

endpackage

// File: rtl/acc_bus_select.sv
module acc_bus_select #(
   parameter int WIDTH = 8,
   parameter int NSRC  = 3
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NSRC-1:0][WIDTH-1:0]  src,
   input  logic [NSRC-1:0]             en,
   output logic [WIDTH-1:0]            bus,
   output logic                        conflict
);

   if (NSRC < 2) begin : g_nsrc_check
      $error("acc_bus_select: NSRC must be at least 2");
   end

   logic [NSRC-1:0][WIDTH-1:0] masked;
   logic [WIDTH-1:0]           merged;

   for (genvar s = 0; s < NSRC; s++) begin : g_mask
      assign masked[s] = en[s] ? src[s] : '0;
   end

   always_comb begin
      merged = '0;
      for (int s = 0; s < NSRC; s++) begin
         merged = merged | masked[s];
      end
   end

   assign conflict = ($countones(en) > 1);
   assign bus      = conflict ? '0 : merged;

   assert_conflict_bus_zero_R7 : assert property (@(posedge clk) disable iff (rst)
      conflict |-> (bus == '0));

   assert_single_source_R2 : assert property (@(posedge clk) disable iff (rst)
      $onehot0(en) |-> !conflict);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_bus_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit SUB_BORROW = 1'b1
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] result,
   output logic             carry,
   output logic             zero
);

   localparam int EXT = WIDTH + 1;

   logic [EXT-1:0] sum_ext;
   logic [EXT-1:0] diff_ext;
   logic           sub_flag;

   assign sum_ext  = {1'b0, opa} + {1'b0, opb};
   assign diff_ext = {1'b0, opa} - {1'b0, opb};

   if (SUB_BORROW) begin : g_borrow
      assign sub_flag = diff_ext[WIDTH];
   end else begin : g_carry_out
      assign sub_flag = ~diff_ext[WIDTH];
   end

   always_comb begin
      unique case (op)
         OP_ADD: begin result = sum_ext[WIDTH-1:0];  carry = sum_ext[WIDTH]; end
         OP_SUB: begin result = diff_ext[WIDTH-1:0]; carry = sub_flag;       end
         OP_AND: begin result = opa & opb;           carry = 1'b0;           end
         OP_OR:  begin result = opa | opb;           carry = 1'b0;           end
         default: begin result = '0;                 carry = 1'b0;           end
      endcase
   end

   assign zero = (result == '0);

endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   assert_hold_R8 : assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));

endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath
   import acc_bus_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit SUB_BORROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] data_in,
   input  logic             drv_in,
   input  logic             drv_x,
   input  logic             drv_z,
   input  logic             ld_x,
   input  logic             ld_a,
   input  logic             ld_z,
   input  logic [1:0]       alu_op,
   output logic [WIDTH-1:0] data_out,
   output logic             zero_flag,
   output logic             carry_flag,
   output logic             bus_conflict
);

   if (WIDTH < 2) begin : g_width_check
      $error("acc_bus_datapath: WIDTH must be at least 2");
   end

   localparam int FLAGS = 2;

   logic [WIDTH-1:0]                x_q, a_q, z_q, bus_val, alu_res;
   logic [SRC_COUNT-1:0][WIDTH-1:0] srcs;
   logic [SRC_COUNT-1:0]            src_en;
   logic                            alu_c, alu_zero;
   logic [FLAGS-1:0]                flags_q;

   assign srcs[SRC_IN]   = data_in;
   assign srcs[SRC_X]    = x_q;
   assign srcs[SRC_Z]    = z_q;
   assign src_en[SRC_IN] = drv_in;
   assign src_en[SRC_X]  = drv_x;
   assign src_en[SRC_Z]  = drv_z;

   acc_bus_select #(.WIDTH(WIDTH), .NSRC(SRC_COUNT)) u_bus (
      .clk(clk), .rst(rst), .src(srcs), .en(src_en),
      .bus(bus_val), .conflict(bus_conflict)
   );

   acc_alu #(.WIDTH(WIDTH), .SUB_BORROW(SUB_BORROW)) u_alu (
      .opa(a_q), .opb(bus_val), .op(alu_op_e'(alu_op)),
      .result(alu_res), .carry(alu_c), .zero(alu_zero)
   );

   acc_reg #(.WIDTH(WIDTH)) u_reg_x (
      .clk(clk), .rst(rst), .load(ld_x), .d(bus_val), .q(x_q));
   acc_reg #(.WIDTH(WIDTH)) u_reg_a (
      .clk(clk), .rst(rst), .load(ld_a), .d(bus_val), .q(a_q));
   acc_reg #(.WIDTH(WIDTH)) u_reg_z (
      .clk(clk), .rst(rst), .load(ld_z), .d(alu_res), .q(z_q));
   acc_reg #(.WIDTH(FLAGS)) u_reg_flags (
      .clk(clk), .rst(rst), .load(ld_z), .d({alu_c, alu_zero}), .q(flags_q));

   assign data_out   = z_q;
   assign zero_flag  = flags_q[0];
   assign carry_flag = flags_q[1];

   assert_reset_clears_R1 : assert property (@(posedge clk)
      rst |=> (data_out == '0 && !zero_flag && !carry_flag));

   assert_load_from_in_R2 : assert property (@(posedge clk) disable iff (rst)
      (ld_a && drv_in && !drv_x && !drv_z) |=> (a_q == $past(data_in)));

   assert_zero_flag_R5 : assert property (@(posedge clk) disable iff (rst)
      ld_z |=> (zero_flag == (data_out == '0)));

   assert_logic_no_carry_R6 : assert property (@(posedge clk) disable iff (rst)
      (ld_z && alu_op[1]) |=> !carry_flag);

   assert_z_flags_hold_R8 : assert property (@(posedge clk) disable iff (rst)
      !ld_z |=> ($stable(data_out) && $stable(zero_flag) && $stable(carry_flag)));

endmodule

// File: tb/test_acc_bus_datapath.sv
module test_acc_bus_datapath;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] data_in = '0;
   logic         drv_in = 0, drv_x = 0, drv_z = 0;
   logic         ld_x = 0, ld_a = 0, ld_z = 0;
   logic [1:0]   alu_op = 2'b00;
   logic [W-1:0] data_out;
   logic         zero_flag, carry_flag, bus_conflict;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   acc_bus_datapath #(.WIDTH(W)) i_acc_bus_datapath (
      .clk(clk), .rst(rst), .data_in(data_in),
      .drv_in(drv_in), .drv_x(drv_x), .drv_z(drv_z),
      .ld_x(ld_x), .ld_a(ld_a), .ld_z(ld_z), .alu_op(alu_op),
      .data_out(data_out), .zero_flag(zero_flag), .carry_flag(carry_flag),
      .bus_conflict(bus_conflict)
   );

   always #4 clk = ~clk;

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Drive one control word at the falling edge, clock it in,
   // then return at the next falling edge.
   task automatic step(bit di, bit dx, bit dz, bit lx, bit la, bit lz,
                       logic [1:0] op, logic [W-1:0] d);
      drv_in = di; drv_x = dx; drv_z = dz;
      ld_x = lx; ld_a = la; ld_z = lz; alu_op = op; data_in = d;
      @(posedge clk);
      @(negedge clk);
      drv_in = 0; drv_x = 0; drv_z = 0; ld_x = 0; ld_a = 0; ld_z = 0;
   endtask

   task automatic load_a(logic [W-1:0] v); step(1,0,0,0,1,0,2'b00,v); endtask
   task automatic load_x(logic [W-1:0] v); step(1,0,0,1,0,0,2'b00,v); endtask

   // A op X -> Z
   task automatic op_x(logic [1:0] op); step(0,1,0,0,0,1,op,'0); endtask

   // Copy A into Z via OR with zero on the bus
   task automatic read_a(); step(1,0,0,0,0,1,2'b11,8'h00); endtask

   task automatic expect_z(string req, logic [W-1:0] v, bit z, bit c);
      check(req, "data_out", data_out, v);
      check(req, "zero_flag", zero_flag, z);
      check(req, "carry_flag", carry_flag, c);
   endtask

   task automatic t_reset();
      check("R1", "data_out after reset", data_out, 0);
      check("R1", "zero_flag after reset", zero_flag, 0);
      check("R1", "carry_flag after reset", carry_flag, 0);
      check("R7", "bus_conflict idle", bus_conflict, 0);
   endtask

   task automatic t_add();
      load_a(8'h25); load_x(8'h13); op_x(2'b00);
      expect_z("R3", 8'h38, 0, 0);
      load_a(8'hF0); load_x(8'h20); op_x(2'b00);
      expect_z("R6", 8'h10, 0, 1);
      load_a(8'h80); load_x(8'h80); op_x(2'b00);
      expect_z("R5", 8'h00, 1, 1);
   endtask

   task automatic t_sub();
      load_a(8'h50); load_x(8'h20); op_x(2'b01);
      expect_z("R3", 8'h30, 0, 0);
      load_a(8'h20); load_x(8'h50); op_x(2'b01);
      expect_z("R6", 8'hD0, 0, 1);
      load_a(8'h44); load_x(8'h44); op_x(2'b01);
      expect_z("R5", 8'h00, 1, 0);
   endtask

   task automatic t_logic();
      load_a(8'hF0); load_x(8'h3C); op_x(2'b10);
      expect_z("R3", 8'h30, 0, 0);
      load_a(8'h0F); load_x(8'hA0); op_x(2'b11);
      expect_z("R3", 8'hAF, 0, 0);
      load_a(8'h0F); load_x(8'hF0); op_x(2'b10);
      expect_z("R6", 8'h00, 1, 0);
   endtask

   task automatic t_z_feedback();
      load_a(8'h11); load_x(8'h22); op_x(2'b00);   // Z = 33
      step(0,0,1,1,0,0,2'b00,8'hFF);             // X <- Z
      load_a(8'h00); op_x(2'b00);                 // Z = 0 + X
      expect_z("R4", 8'h33, 0, 0);
      step(0,0,1,0,1,0,2'b00,8'hFF);             // A <- Z
      read_a();
      expect_z("R4", 8'h33, 0, 0);
   endtask

   task automatic t_no_source();
      load_a(8'h5A);
      step(0,0,0,0,1,0,2'b00,8'hFF);             // no enable: A <- 0
      read_a();
      expect_z("R2", 8'h00, 1, 0);
   endtask

   task automatic t_conflict();
      load_a(8'h77); load_x(8'h01);
      drv_in = 1; drv_x = 1; data_in = 8'hFF; #1;
      check("R7", "bus_conflict two sources", bus_conflict, 1);
      drv_z = 1; #1;
      check("R7", "bus_conflict three sources", bus_conflict, 1);
      drv_in = 0; drv_x = 0; drv_z = 0; #1;
      check("R7", "bus_conflict cleared", bus_conflict, 0);
      // conflict with ld_z, OR: bus is zero, so Z = A
      step(1,1,0,0,0,1,2'b11,8'hFF);
      expect_z("R7", 8'h77, 0, 0);
      // conflict with ld_a: A becomes zero
      step(1,1,0,0,1,0,2'b00,8'hFF);
      read_a();
      expect_z("R7", 8'h00, 1, 0);
   endtask

   task automatic t_hold();
      load_a(8'hF0); load_x(8'h20); op_x(2'b00);  // Z=10, C=1
      step(1,0,0,1,1,0,2'b01,8'h00);             // X, A change, no ld_z
      expect_z("R8", 8'h10, 0, 1);
      load_a(8'h03);
      step(1,0,0,0,0,0,2'b00,8'hAA);             // X strobe low
      op_x(2'b11);                                // 03 | X
      check("R8", "X kept without strobe", data_out, 8'h03);
   endtask

   task automatic t_same_edge();
      load_a(8'h10);
      step(1,0,0,0,1,1,2'b00,8'h05);             // Z = old A + 05, A <- 05
      expect_z("R9", 8'h15, 0, 0);
      read_a();
      check("R9", "A took bus on same edge", data_out, 8'h05);
      step(1,0,0,1,1,0,2'b00,8'h09);             // X and A both <- 09
      op_x(2'b01);
      expect_z("R9", 8'h00, 1, 0);
   endtask

   task automatic t_mid_reset();
      load_a(8'h12); load_x(8'h34); op_x(2'b00);
      rst = 1;
      @(posedge clk); @(negedge clk);
      rst = 0;
      check("R1", "data_out after mid reset", data_out, 0);
      read_a();
      check("R1", "A cleared by reset", data_out, 0);
      op_x(2'b11);
      check("R1", "X cleared by reset", data_out, 0);
   endtask

   initial begin
      rst = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_z_feedback();
      t_no_source();
      t_conflict();
      t_hold();
      t_same_edge();
      t_mid_reset();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule